// File: doc/BRIEF.md
# Saturating Register-Amount Shifter

This block shifts a 32-bit operand left logically, right logically or right arithmetically by an amount taken from a full 32-bit register value. Amounts too large for the word are not reduced modulo 32: the result saturates to zero, or to a full sign fill for the arithmetic right shift. This way software sees defined results for any amount a register can hold.

The shift is built as a compact combinational datapath. A parameter adds an optional output register stage. With that stage in place, the result and a valid flag appear one cycle after the inputs are presented. With the stage left out, the result follows the inputs at once and the valid output copies the input valid.

Top module: `sat_shifter`

## Requirements
- R1: The shift amount is the whole 32-bit value of `amount_i`; no upper bits are ignored.
- R2: With `op_i` = 2'b00 (logical left) and an amount of 32 or more, the result is zero.
- R3: With `op_i` = 2'b01 (logical right) and an amount of 32 or more, the result is zero.
- R4: With `op_i` = 2'b10 (arithmetic right) and an amount of 31 or more, the result is 32'hFFFFFFFF when operand bit 31 is 1 and zero otherwise.
- R5: Amounts from 1 to 31 give ordinary shifts: left and logical right fill with zeros, and arithmetic right copies operand bit 31 into the vacated bits.
- R6: An amount of zero returns the operand unchanged for every operation.
- R7: `op_i` = 2'b11 is reserved and returns the operand unchanged whatever the amount.
- R8: With `OUT_REG`=1, `result_o` and `valid_o` are registered and show the inputs of the previous cycle. Synchronous active-high `rst` clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used only when OUT_REG=1) |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Input qualifier |
| op_i | input | 2 | Operation select: 00 SLL, 01 SRL, 10 SRA, 11 pass |
| operand_i | input | 32 | Value to be shifted |
| amount_i | input | 32 | Full shift amount |
| result_o | output | 32 | Shifted result |
| valid_o | output | 1 | Result qualifier |

## Verification
The checker assumes that `op_i`, `operand_i` and `amount_i` are known, non-X values in every cycle where `valid_i` is high. It compares the registered output against the sampled inputs of the previous cycle only under that condition. The bench always drives defined values. It mixes directed amounts (0, 1, 30, 31, 32, 33 and all ones, each with positive and negative operands) with random amounts drawn so that the in-range and saturating regions are both covered.

// File: rtl/sat_shift_pkg.sv
package sat_shift_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned IDX_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        SH_LEFT  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_ARITH = 2'b10,
        SH_PASS  = 2'b11
    } shift_op_e;

    typedef struct packed {
        logic              big;   // amount >= WORD_W
        logic [IDX_W-1:0]  idx;   // low bits when in range
    } amt_dec_t;

    // Reverse bit order of a word
    function automatic logic [WORD_W-1:0] bit_rev(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[i] = v[WORD_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/sat_shift_amt_dec.sv
module sat_shift_amt_dec
    import sat_shift_pkg::*;
#(
    parameter int unsigned AMT_W = 32
) (
    input  logic [AMT_W-1:0] amount_i,
    output amt_dec_t         dec_o
);
    localparam int unsigned HI_W = AMT_W - IDX_W;

    always_comb begin
        dec_o.idx = amount_i[IDX_W-1:0];
        dec_o.big = |amount_i[AMT_W-1:IDX_W];
    end

    logic unused_hi;
    assign unused_hi = (HI_W == 0);
endmodule

// File: rtl/sat_shift_core.sv
module sat_shift_core
    import sat_shift_pkg::*;
(
    input  shift_op_e         op_i,
    input  logic [WORD_W-1:0] operand_i,
    input  amt_dec_t          dec_i,
    output logic [WORD_W-1:0] result_o
);
    // One right-shift barrel; a left shift reverses bits in and out.
    logic [WORD_W-1:0] stage [IDX_W+1];
    logic              fill;
    logic [WORD_W-1:0] pre;

    always_comb begin
        pre  = (op_i == SH_LEFT) ? bit_rev(operand_i) : operand_i;
        fill = (op_i == SH_ARITH) & operand_i[WORD_W-1];
    end

    assign stage[0] = pre;

    for (genvar s = 0; s < IDX_W; s++) begin : g_stage
        localparam int unsigned D = 1 << s;
        assign stage[s+1] = dec_i.idx[s]
            ? {{D{fill}}, stage[s][WORD_W-1:D]}
            : stage[s];
    end

    always_comb begin
        unique case (op_i)
            SH_PASS:  result_o = operand_i;
            SH_LEFT:  result_o = dec_i.big ? '0 : bit_rev(stage[IDX_W]);
            SH_RIGHT: result_o = dec_i.big ? '0 : stage[IDX_W];
            default:  result_o = dec_i.big ? {WORD_W{fill}} : stage[IDX_W];
        endcase
    end
endmodule

// File: rtl/sat_shifter.sv
module sat_shifter
    import sat_shift_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [1:0]        op_i,
    input  logic [WORD_W-1:0] operand_i,
    input  logic [WORD_W-1:0] amount_i,
    output logic [WORD_W-1:0] result_o,
    output logic              valid_o
);
    amt_dec_t          dec;
    logic [WORD_W-1:0] comb_res;

    sat_shift_amt_dec #(.AMT_W(WORD_W)) u_dec (
        .amount_i (amount_i),
        .dec_o    (dec)
    );

    sat_shift_core u_core (
        .op_i      (shift_op_e'(op_i)),
        .operand_i (operand_i),
        .dec_i     (dec),
        .result_o  (comb_res)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                result_o <= '0;
                valid_o  <= 1'b0;
            end else begin
                result_o <= comb_res;
                valid_o  <= valid_i;
            end
        end
    end else begin : g_comb
        assign result_o = comb_res;
        assign valid_o  = valid_i;
        logic unused_clk;
        assign unused_clk = clk ^ rst;
    end
endmodule

// File: rtl/sat_shifter_chk.sv
module sat_shifter_chk
    import sat_shift_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [1:0]        op_i,
    input logic [WORD_W-1:0] operand_i,
    input logic [WORD_W-1:0] amount_i,
    input logic [WORD_W-1:0] result_o,
    input logic              valid_o
);
    logic armed;
    always_ff @(posedge clk) armed <= rst ? 1'b0 : 1'b1;

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (valid_o == $past(valid_i)));

    // R2
    sll_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 2'b00 && amount_i >= 32) |=> (result_o == '0));

    // R3
    srl_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 2'b01 && amount_i >= 32) |=> (result_o == '0));

    // R4
    sra_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 2'b10 && amount_i >= 31)
        |=> (result_o == {WORD_W{$past(operand_i[WORD_W-1])}}));

    // R6
    zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && amount_i == '0) |=> (result_o == $past(operand_i)));

    // R7
    pass_op_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 2'b11) |=> (result_o == $past(operand_i)));

    // R1
    hi_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i != 2'b11 && operand_i != '0 && !operand_i[WORD_W-1]
         && amount_i[WORD_W-1]) |=> (result_o == '0));
endmodule

bind sat_shifter sat_shifter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .operand_i (operand_i),
    .amount_i  (amount_i),
    .result_o  (result_o),
    .valid_o   (valid_o)
);

// File: tb/sat_shifter_bench.sv
module sat_shifter_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] operand_i = '0;
    logic [31:0] amount_i = '0;
    logic [31:0] result_o;
    logic        valid_o;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_shifter u_sat_shifter (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .operand_i(operand_i), .amount_i(amount_i),
        .result_o(result_o), .valid_o(valid_o)
    );

    function automatic logic [31:0] ref_shift(input logic [1:0] op,
                                              input logic [31:0] a,
                                              input logic [31:0] n);
        logic [31:0] r;
        r = a;
        if (op == 2'b11) return a;
        for (longint unsigned k = 0; k < n && k < 40; k++) begin
            case (op)
                2'b00:   r = {r[30:0], 1'b0};
                2'b01:   r = {1'b0, r[31:1]};
                default: r = {a[31], r[31:1]};
            endcase
        end
        return r;
    endfunction

    function automatic string req_of(input logic [1:0] op, input logic [31:0] n);
        if (op == 2'b11) return "R7";
        if (n == 0) return "R6";
        if (n[31:5] != 0 && n != 32'hFFFF_FFFF && n != 32 && n != 33) return "R1";
        if (op == 2'b00 && n > 31) return "R2";
        if (op == 2'b01 && n > 31) return "R3";
        if (op == 2'b10 && n > 30) return "R4";
        return "R5";
    endfunction

    task automatic apply(input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] n);
        logic [31:0] exp;
        exp = ref_shift(op, a, n);
        @(negedge clk);
        valid_i = 1'b1; op_i = op; operand_i = a; amount_i = n;
        @(negedge clk);
        n_run++;
        if (result_o !== exp || valid_o !== 1'b1) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h n=%h actual=%h/%b expected=%h/1",
                     req_of(op, n), op, a, n, result_o, valid_o, exp);
        end
        valid_i = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] amts [7];
        logic [31:0] ops  [4];
        void'($urandom(32'd1234));
        amts = '{32'd0, 32'd1, 32'd30, 32'd31, 32'd32, 32'd33, 32'hFFFF_FFFF};
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_run++; // R8 reset state
        if (result_o !== '0 || valid_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 reset actual=%h/%b expected=0/0", result_o, valid_o);
        end
        rst = 1'b0;
        @(negedge clk);
        n_run++; // R8 valid follows input valid (idle)
        if (valid_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 idle valid actual=%b expected=0", valid_o);
        end
        for (int o = 0; o < 4; o++)
            for (int k = 0; k < 7; k++) begin
                apply(2'(o), 32'h3C5A_9617, amts[k]);
                apply(2'(o), 32'hC5A3_6981, amts[k]);
            end
        // R1: only upper bits of amount set
        apply(2'b00, 32'h0000_0001, 32'h0001_0000);
        apply(2'b01, 32'h8000_0000, 32'h8000_0001);
        apply(2'b10, 32'h7FFF_FFFF, 32'h0000_0100);
        apply(2'b10, 32'h8000_0000, 32'h0000_0040);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] n;
            n = ($urandom % 3 == 0) ? $urandom : ($urandom % 40);
            apply(2'($urandom), $urandom, n);
        end
        @(negedge clk);
        n_run++; // R8 valid drops one cycle after input
        if (valid_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 valid drop actual=%b expected=0", valid_o);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule